// File: doc/BRIEF.md
# Multi-Mode GPIO Port Controller

An eight-pin general-purpose I/O port in which every pin picks its own behaviour from four configuration bits: its output value bit, its direction bit and two mode bits. A small register bus writes and reads those registers, and each pin drives a pad through an output value and an output enable while its pad input is brought into the clock domain by a synchronizer. The pin modes are push-pull output, plain input, open-drain, open-source, forced high impedance, dual-edge interrupt and alternate-function pass-through.

In dual-edge interrupt mode both transitions of the synchronized input set a per-pin pending interrupt, which software clears by writing 1 to that pin's bit at the interrupt-clear address. In alternate-function mode the pad is handed to a peripheral: its output value and enable drive the pad, and the synchronized pad input is returned to it. Outside that mode the peripheral input is held at a per-pin idle level, by default 1 so that active-low inputs read as not asserted.

Top module: `gpio_port`

## Requirements
- R1: After reset the value register is 0, the direction register is all ones, both mode registers are 0 and no interrupt is pending, so every pin is a plain input (mode 2): pad_oe is 0 and alt_in equals the idle level.
- R2: A write at address 1, 3 or 4 (direction, mode bit A, mode bit B) updates that register at the clock edge and a read at the same address returns it; a read at address 0 returns the synchronized pad input, not the written value; addresses 5 to 7 read as 0 and ignore writes.
- R3: Per pin, with B=mode bit B, A=mode bit A, R=direction, V=value: B=1,A=1 is alternate (mode 7); B=0,A=0 is input (R=1, mode 2) or push-pull (R=0, mode 1); B=0,A=1 is open-source (R=1, mode 4) or open-drain (R=0, mode 3); B=1,A=0 is high impedance (R=1, mode 5), dual-edge interrupt (R=0,V=1, mode 6) or, for R=0,V=0, high impedance.
- R4: In push-pull mode pad_oe is 1 and pad_out equals the value bit.
- R5: In open-drain mode a value bit of 0 drives the pad low (pad_oe=1, pad_out=0) and a value bit of 1 releases it (pad_oe=0).
- R6: In open-source mode a value bit of 1 drives the pad high (pad_oe=1, pad_out=1) and a value bit of 0 releases it (pad_oe=0).
- R7: In input, high-impedance, interrupt and unlisted combinations pad_oe is 0 whatever the value bit.
- R8: In interrupt mode a rising or a falling pad transition sets the pin's bit of irq at the third rising clock edge after the pad change; transitions in other modes set nothing.
- R9: A write at address 2 clears each pending interrupt whose write-data bit is 1 and leaves the others; when a detected edge coincides with the clear, the interrupt stays pending.
- R10: In alternate mode pad_out and pad_oe follow alt_out and alt_oe in the same cycle and the value bit has no effect.
- R11: alt_in equals the synchronized pad input in alternate mode and the per-pin idle level otherwise.
- R12: A read at address 2 returns the pending interrupt bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Raw pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |
| alt_in | output | 8 | Inputs returned to the peripheral |
| irq | output | 8 | Per-pin pending interrupt requests |

## Verification
Register writes reach the pad controls and the read mux one clock edge after the write strobe, alt_out and alt_oe reach the pads in the same cycle, a pad change reaches the address-0 read and alt_in after two rising edges, and an interrupt sets one edge after that. A behavioural model in the bench mirrors these delays with shifted history of the pad input and is compared against every output on each falling edge, so each result is inspected exactly in the cycle it becomes due. Directed sequences line a clear write up with the edge-detect cycle and check the pending bit afterwards.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADR_VALUE = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_DIR   = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_ICLR  = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_MODEA = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_MODEB = 3'd4;

   typedef enum logic [2:0] {
      PM_NONE   = 3'd0,
      PM_PUSH   = 3'd1,
      PM_IN     = 3'd2,
      PM_ODRAIN = 3'd3,
      PM_OSRC   = 3'd4,
      PM_HIZ    = 3'd5,
      PM_EDGE   = 3'd6,
      PM_ALT    = 3'd7
   } pin_mode_e;

   function automatic pin_mode_e decode_mode(input logic v, input logic dir,
                                             input logic ma, input logic mb);
      pin_mode_e m;
      if (mb && ma)        m = PM_ALT;
      else if (!mb && !ma) m = dir ? PM_IN : PM_PUSH;
      else if (ma)         m = dir ? PM_OSRC : PM_ODRAIN;
      else if (dir)        m = PM_HIZ;
      else                 m = v ? PM_EDGE : PM_NONE;
      return m;
   endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  value_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  modea_q,
   output logic [WIDTH-1:0]  modeb_q,
   output logic [WIDTH-1:0]  clr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         dir_q   <= '1;
         modea_q <= '0;
         modeb_q <= '0;
      end else if (we) begin
         case (addr)
            ADR_VALUE: value_q <= wdata;
            ADR_DIR:   dir_q   <= wdata;
            ADR_MODEA: modea_q <= wdata;
            ADR_MODEB: modeb_q <= wdata;
            default: ;
         endcase
      end
   end

   assign clr_o = (we && addr == ADR_ICLR) ? wdata : '0;

   a_r2_dir_written: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADR_DIR) |=> (dir_q == $past(wdata)));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= raw_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
   import gpio_port_pkg::*;
#(
   parameter logic IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic value_i,
   input  logic dir_i,
   input  logic modea_i,
   input  logic modeb_i,
   input  logic sync_i,
   input  logic clr_i,
   input  logic alt_out_i,
   input  logic alt_oe_i,
   output logic pad_out_o,
   output logic pad_oe_o,
   output logic alt_in_o,
   output logic irq_o
);

   pin_mode_e mode;
   logic      prev_q;
   logic      edge_hit;

   assign mode = decode_mode(value_i, dir_i, modea_i, modeb_i);

   always_comb begin
      pad_out_o = 1'b0;
      pad_oe_o  = 1'b0;
      case (mode)
         PM_PUSH:   begin pad_out_o = value_i;   pad_oe_o = 1'b1;     end
         PM_ODRAIN: begin pad_out_o = 1'b0;      pad_oe_o = !value_i; end
         PM_OSRC:   begin pad_out_o = 1'b1;      pad_oe_o = value_i;  end
         PM_ALT:    begin pad_out_o = alt_out_i; pad_oe_o = alt_oe_i; end
         default: ;
      endcase
   end

   assign alt_in_o = (mode == PM_ALT) ? sync_i : IDLE;
   assign edge_hit = (mode == PM_EDGE) && (sync_i != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         irq_o  <= 1'b0;
      end else begin
         prev_q <= sync_i;
         if (edge_hit)   irq_o <= 1'b1;
         else if (clr_i) irq_o <= 1'b0;
      end
   end

   a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_ODRAIN && pad_oe_o) |-> !pad_out_o);
   a_r6_os_never_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_OSRC && pad_oe_o) |-> pad_out_o);
   a_r7_hiz_released: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_HIZ) |-> !pad_oe_o);
   a_r8_irq_only_edge_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(mode == PM_EDGE));
   a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !edge_hit) |=> !irq_o);
   a_r9_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_i) |=> irq_o);
   a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != PM_ALT) |-> (alt_in_o == IDLE));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int         WIDTH       = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ALT_IDLE    = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   input  logic [WIDTH-1:0]  alt_out,
   input  logic [WIDTH-1:0]  alt_oe,
   output logic [WIDTH-1:0]  alt_in,
   output logic [WIDTH-1:0]  irq
);

   localparam int IDLE_W = $bits(ALT_IDLE);

   if (WIDTH < 1 || WIDTH > IDLE_W) begin : g_bad_width
      $error("gpio_port: WIDTH must lie in 1..%0d", IDLE_W);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] value_q, dir_q, modea_q, modeb_q, clr, sync;

   gpio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .value_q(value_q), .dir_q(dir_q), .modea_q(modea_q), .modeb_q(modeb_q),
      .clr_o(clr)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(pad_in), .sync_o(sync)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      gpio_pin #(.IDLE(ALT_IDLE[i])) u_pin (
         .clk(clk), .rst_n(rst_n),
         .value_i(value_q[i]), .dir_i(dir_q[i]),
         .modea_i(modea_q[i]), .modeb_i(modeb_q[i]),
         .sync_i(sync[i]), .clr_i(clr[i]),
         .alt_out_i(alt_out[i]), .alt_oe_i(alt_oe[i]),
         .pad_out_o(pad_out[i]), .pad_oe_o(pad_oe[i]),
         .alt_in_o(alt_in[i]), .irq_o(irq[i])
      );
   end

   always_comb begin
      case (bus_addr)
         ADR_VALUE: bus_rdata = sync;
         ADR_DIR:   bus_rdata = dir_q;
         ADR_ICLR:  bus_rdata = irq;
         ADR_MODEA: bus_rdata = modea_q;
         ADR_MODEB: bus_rdata = modeb_q;
         default:   bus_rdata = '0;
      endcase
   end

   a_r12_read_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADR_ICLR) |-> (bus_rdata == irq));
   a_r1_sync_settles: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADR_VALUE && $stable(pad_in) && $past($stable(pad_in))
       && $past($stable(pad_in), 2)) |-> (bus_rdata == pad_in));

endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] pad_in = 8'h00, alt_out = 8'h00, alt_oe = 8'h00;
   logic [7:0] bus_rdata, pad_out, pad_oe, alt_in, irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   gpio_port i_gpio_port (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
      .alt_in(alt_in), .irq(irq)
   );

   // behavioural reference state
   logic [7:0] m_val, m_dir, m_ma, m_mb, m_irq, m_s1, m_sync, m_prev;

   function automatic int pin_mode(int i);
      if (m_mb[i] && m_ma[i])   return 7;
      if (!m_mb[i] && !m_ma[i]) return m_dir[i] ? 2 : 1;
      if (m_ma[i])              return m_dir[i] ? 4 : 3;
      if (m_dir[i])             return 5;
      return m_val[i] ? 6 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_val <= 0; m_dir <= 8'hFF; m_ma <= 0; m_mb <= 0;
         m_irq <= 0; m_s1 <= 0; m_sync <= 0; m_prev <= 0;
      end else begin
         for (int i = 0; i < 8; i++) begin
            if (pin_mode(i) == 6 && m_sync[i] != m_prev[i]) m_irq[i] <= 1'b1;
            else if (bus_we && bus_addr == 3'd2 && bus_wdata[i]) m_irq[i] <= 1'b0;
         end
         m_s1 <= pad_in; m_sync <= m_s1; m_prev <= m_sync;
         if (bus_we) begin
            if (bus_addr == 3'd0) m_val <= bus_wdata;
            if (bus_addr == 3'd1) m_dir <= bus_wdata;
            if (bus_addr == 3'd3) m_ma  <= bus_wdata;
            if (bus_addr == 3'd4) m_mb  <= bus_wdata;
         end
      end
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare();
      logic [7:0] e_oe, e_out, e_alt, e_rd;
      for (int i = 0; i < 8; i++) begin
         e_oe[i] = 1'b0; e_out[i] = 1'b0; e_alt[i] = 1'b1;
         case (pin_mode(i))
            1: begin e_oe[i] = 1'b1;       e_out[i] = m_val[i]; end
            3: begin e_oe[i] = !m_val[i];  e_out[i] = 1'b0;     end
            4: begin e_oe[i] = m_val[i];   e_out[i] = 1'b1;     end
            7: begin e_oe[i] = alt_oe[i];  e_out[i] = alt_out[i]; e_alt[i] = m_sync[i]; end
            default: ;
         endcase
      end
      case (bus_addr)
         3'd0: e_rd = m_sync;
         3'd1: e_rd = m_dir;
         3'd2: e_rd = m_irq;
         3'd3: e_rd = m_ma;
         3'd4: e_rd = m_mb;
         default: e_rd = 8'h00;
      endcase
      chk(pad_oe, e_oe, "R4/R5/R6/R7/R10 pad_oe");
      chk(pad_out & e_oe, e_out & e_oe, "R4/R5/R6/R10 pad_out");
      chk(alt_in, e_alt, "R11 alt_in");
      chk(irq, m_irq, "R8/R9 irq");
      chk(bus_rdata, e_rd, "R2/R12 rdata");
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      bus_addr = 3'd1;
      tick();
      // R1 reset state
      chk(pad_oe, 8'h00, "R1 reset pad_oe");
      chk(alt_in, 8'hFF, "R1 reset alt_in");
      chk(irq, 8'h00, "R1 reset irq");
      chk(bus_rdata, 8'hFF, "R1 reset dir");

      // R3 R4 push-pull
      wr(3'd0, 8'hA5);
      wr(3'd1, 8'h00);
      chk(pad_oe, 8'hFF, "R3 R4 push-pull oe");
      chk(pad_out, 8'hA5, "R4 push-pull value");

      // R2 data address returns synchronized pad, not written value
      pad_in = 8'h3C; bus_addr = 3'd0;
      tick(); tick(); tick();
      chk(bus_rdata, 8'h3C, "R2 value read is pad");
      wr(3'd5, 8'h77); bus_addr = 3'd5; tick();
      chk(bus_rdata, 8'h00, "R2 unused address");

      // R5 R6 open-drain on high nibble, open-source on low nibble
      wr(3'd3, 8'hFF);
      wr(3'd1, 8'h0F);
      wr(3'd0, 8'h5A);
      chk(pad_oe, 8'hAA, "R5/R6 oe");
      chk(pad_out & pad_oe, 8'h0A, "R5/R6 out");

      // R7 R8 low nibble interrupt mode, high nibble forced hi-z
      wr(3'd3, 8'h00);
      wr(3'd4, 8'hFF);
      wr(3'd1, 8'hF0);
      wr(3'd0, 8'hFF);
      chk(pad_oe, 8'h00, "R7 hiz and irq modes");
      pad_in = 8'h00; repeat (4) tick();
      wr(3'd2, 8'hFF);
      pad_in = 8'hF3;         // rising on 0,1 and 4..7
      tick(); tick();
      chk(irq, 8'h00, "R8 not yet");
      tick();
      chk(irq, 8'h03, "R8 rising edge");
      pad_in = 8'hF1;         // falling on pin 1
      repeat (3) tick();
      chk(irq, 8'h03, "R8 falling edge kept");
      wr(3'd2, 8'h01);
      chk(irq, 8'h02, "R9 selective clear");
      bus_addr = 3'd2; tick();
      chk(bus_rdata, 8'h02, "R12 read pending");
      // R9 clear coinciding with edge on pin 1
      pad_in = 8'hF3;
      tick(); tick();
      wr(3'd2, 8'h02);
      chk(irq, 8'h02, "R9 edge beats clear");

      // R10 R11 alternate mode
      wr(3'd3, 8'hFF);
      alt_out = 8'h96; alt_oe = 8'hF0; pad_in = 8'h69;
      tick();
      chk(pad_oe, 8'hF0, "R10 alt oe");
      chk(pad_out, 8'h96, "R10 alt out");
      wr(3'd0, 8'h00);
      chk(pad_out, 8'h96, "R10 value ignored");
      tick(); tick();
      chk(alt_in, 8'h69, "R11 alt input");
      wr(3'd4, 8'h0F);
      chk(alt_in, 8'hF9, "R11 idle when not alt");

      // mixed random traffic against the model
      for (int n = 0; n < 400; n++) begin
         bus_we    = ($urandom_range(0, 2) == 0);
         bus_addr  = 3'($urandom_range(0, 7));
         bus_wdata = 8'($urandom);
         pad_in    = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pad_in;
         alt_out   = 8'($urandom);
         alt_oe    = 8'($urandom);
         tick();
      end
      bus_we = 1'b0;
      tick();

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule